// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block brings one switchable power island up and down in a fixed, handshaked order. A one-cycle request pulse on `on_req` or `off_req` starts a sequence. The sequencer then steps a control word that drives the island's switch, isolation, reset, clock-gate and SRAM-sleep controls. Each change is held for at least one clock before the next change is applied. At two points it stops and waits for feedback: the dual power-acknowledge pair, and the masked SRAM sleep-acknowledge field. A bus-protection request fences the island's bus ports while the island is not fully powered.

The SRAM sleep bits, the SRAM acknowledge bits that are waited on, and the bus-protection lines are set by parameter masks. When a mask is zero, its wait or its protection step has no effect. Every wait is bounded by `TIMEOUT_CYC` cycles. If a wait runs out, the sequence aborts into an error state and the control word is frozen until the next request. The block has no data stream; all pins are plain control and status levels.

Top module: `pwr_dom_seq`

## Requirements
- R1: After reset:
  - `ctl_word` has isolation (bit 1) and clock-off (bit 4) set.
  - Reset release (bit 0), primary switch (bit 2) and secondary switch (bit 3) are clear.
  - The SRAM sleep field, bits 8 and up, equals `SRAM_PDN_MASK`.
  - `bus_prot` equals `BP_MASK`.
  - `state` is 0 (off), and `done`, `busy` and `error` are low.
- R2: The power-up sequence starts when a request is accepted. The clock edge that accepts `on_req` sets bit 2. The next edge sets bit 3.
- R3: A power-acknowledge wait ends only when both `pwr_ack_a` and `pwr_ack_b` have the target level. While the two disagree, or still have the old level, `ctl_word` does not change.
- R4: On successive edges after both acks are seen high, the sequencer does the following, in this order:
  - clears bit 4;
  - clears bit 1;
  - sets bit 0;
  - clears the `SRAM_PDN_MASK` bits of the sleep field.
- R5: The sequencer then waits until all `sram_ack` bits selected by `SRAM_ACK_MASK` read 0; unselected bits are ignored. On the edge that sees this, `bus_prot` is cleared, `state` becomes 1 (on) and `done` pulses for one cycle.
- R6: The power-down sequence starts when a request is accepted. The edge that accepts `off_req` sets `bus_prot` to `BP_MASK`. The next edge sets the masked sleep bits. The sequencer then waits until all selected `sram_ack` bits read 1.
- R7: After that wait, on successive edges, the sequencer:
  - sets bit 1;
  - clears bit 0;
  - sets bit 4;
  - clears bit 2;
  - clears bit 3.

  It then waits for both acks low. On that edge `state` becomes 0 and `done` pulses.
- R8: With `SRAM_ACK_MASK` zero, the SRAM wait ends on its first cycle whatever `sram_ack` is. With `BP_MASK` zero, `bus_prot` stays 0.
- R9: A wait that has not ended after `TIMEOUT_CYC` cycles aborts. `state` becomes 2, `error` goes high, `busy` goes low, and `ctl_word` and `bus_prot` hold their values.
- R10: From the error state, the next request clears `error` and runs the full requested sequence.
- R11: A request that matches the settled state sets `done` on the next cycle. It does not change `ctl_word` or `bus_prot`.
- R12: Requests that arrive while a sequence runs are ignored.
- R13: `busy` is high from the edge after an accepted request until the sequence ends. It is never high together with `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_req | input | 1 | Power-up request pulse (wins if both pulse) |
| off_req | input | 1 | Power-down request pulse |
| pwr_ack_a | input | 1 | First power-acknowledge status |
| pwr_ack_b | input | 1 | Second power-acknowledge status |
| sram_ack | input | SACK_W | SRAM sleep acknowledge field |
| ctl_word | output | 8+SRAM_W | Island control word (bits 0..4 controls, 8+ SRAM sleep) |
| bus_prot | output | BP_W | Bus-protection request lines |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Sequence in progress |
| error | output | 1 | A wait timed out |
| state | output | 4 | Sequencer state (0 off, 1 on, 2 error, others transitional) |

## Verification
Every control step is one register stage, so each field change in R2, R4, R6 and R7 is due exactly one edge after the step before it. An acknowledge that is already present when a wait begins ends that wait on its first edge. A timeout fires on edge `TIMEOUT_CYC + 1` counted from the accepting edge. The bench drives inputs and samples outputs on falling edges. After each rising edge it updates its own expected control word and compares it. Mismatched and partial acknowledge patterns of swept lengths show that no step fires early and none is late.

// File: rtl/pwr_dom_pkg.sv
package pwr_dom_pkg;

  // control word bit positions (neighbour logic decodes these)
  localparam int CB_RSTN     = 0;
  localparam int CB_ISO      = 1;
  localparam int CB_PON      = 2;
  localparam int CB_PON2     = 3;
  localparam int CB_CLKOFF   = 4;
  localparam int CB_SRAM_LSB = 8;

  typedef enum logic [3:0] {
    S_OFF    = 4'd0,
    S_ON     = 4'd1,
    S_ERR    = 4'd2,
    U_PWR2   = 4'd3,
    U_WACK   = 4'd4,
    U_ISO    = 4'd5,
    U_RST    = 4'd6,
    U_SRAM   = 4'd7,
    U_WSRAM  = 4'd8,
    D_SRAM   = 4'd9,
    D_WSRAM  = 4'd10,
    D_RST    = 4'd11,
    D_CLK    = 4'd12,
    D_PWR1   = 4'd13,
    D_PWR2   = 4'd14,
    D_WACK   = 4'd15
  } seq_st_e;

endpackage

// File: rtl/pwr_dom_ack_eval.sv
module pwr_dom_ack_eval #(
  parameter int              SACK_W        = 4,
  parameter logic [SACK_W-1:0] SRAM_ACK_MASK = '1
) (
  input  logic              ack_a,
  input  logic              ack_b,
  input  logic [SACK_W-1:0] sram_ack,
  output logic              pwr_up_ok,
  output logic              pwr_dn_ok,
  output logic              sram_awake,
  output logic              sram_asleep
);

  logic [SACK_W-1:0] sel;

  assign sel         = sram_ack & SRAM_ACK_MASK;
  // a split pair is transitional: neither condition holds
  assign pwr_up_ok   = ack_a & ack_b;
  assign pwr_dn_ok   = ~ack_a & ~ack_b;
  // a zero mask makes both SRAM conditions trivially true
  assign sram_awake  = (sel == '0);
  assign sram_asleep = (sel == SRAM_ACK_MASK);

endmodule

// File: rtl/pwr_dom_wdog.sv
module pwr_dom_wdog #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  localparam int            CW   = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run)         cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == LAST);

endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
  import pwr_dom_pkg::*;
#(
  parameter int                SRAM_W        = 4,
  parameter logic [SRAM_W-1:0] SRAM_PDN_MASK = '1,
  parameter int                SACK_W        = 4,
  parameter logic [SACK_W-1:0] SRAM_ACK_MASK = '1,
  parameter int                BP_W          = 4,
  parameter logic [BP_W-1:0]   BP_MASK       = 4'h5,
  parameter int                TIMEOUT_CYC   = 1024
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        on_req,
  input  logic                        off_req,
  input  logic                        pwr_ack_a,
  input  logic                        pwr_ack_b,
  input  logic [SACK_W-1:0]           sram_ack,
  output logic [CB_SRAM_LSB+SRAM_W-1:0] ctl_word,
  output logic [BP_W-1:0]             bus_prot,
  output logic                        done,
  output logic                        busy,
  output logic                        error,
  output logic [3:0]                  state
);

  localparam int PAD_W = CB_SRAM_LSB - CB_CLKOFF - 1;

  seq_st_e           st_q;
  logic              rstn_q, iso_q, pon_q, pon2_q, clkoff_q, done_q;
  logic [SRAM_W-1:0] pdn_q;
  logic [BP_W-1:0]   bp_q;
  logic              up_ok, dn_ok, sram_awake, sram_asleep;
  logic              in_wait, expired;

  pwr_dom_ack_eval #(
    .SACK_W        (SACK_W),
    .SRAM_ACK_MASK (SRAM_ACK_MASK)
  ) u_eval (
    .ack_a       (pwr_ack_a),
    .ack_b       (pwr_ack_b),
    .sram_ack    (sram_ack),
    .pwr_up_ok   (up_ok),
    .pwr_dn_ok   (dn_ok),
    .sram_awake  (sram_awake),
    .sram_asleep (sram_asleep)
  );

  assign in_wait = (st_q == U_WACK) || (st_q == U_WSRAM) ||
                   (st_q == D_WSRAM) || (st_q == D_WACK);

  pwr_dom_wdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (in_wait),
    .expired (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_OFF;
      rstn_q   <= 1'b0;
      iso_q    <= 1'b1;
      pon_q    <= 1'b0;
      pon2_q   <= 1'b0;
      clkoff_q <= 1'b1;
      pdn_q    <= SRAM_PDN_MASK;
      bp_q     <= BP_MASK;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_OFF, S_ON, S_ERR: begin
          if (on_req) begin
            if (st_q == S_ON) done_q <= 1'b1;
            else begin
              pon_q <= 1'b1;
              st_q  <= U_PWR2;
            end
          end else if (off_req) begin
            if (st_q == S_OFF) done_q <= 1'b1;
            else begin
              bp_q <= BP_MASK;
              st_q <= D_SRAM;
            end
          end
        end
        // ---- power-up ----
        U_PWR2: begin pon2_q <= 1'b1; st_q <= U_WACK; end
        U_WACK: begin
          if (up_ok) begin
            clkoff_q <= 1'b0;
            st_q     <= U_ISO;
          end else if (expired) st_q <= S_ERR;
        end
        U_ISO:  begin iso_q  <= 1'b0; st_q <= U_RST;  end
        U_RST:  begin rstn_q <= 1'b1; st_q <= U_SRAM; end
        U_SRAM: begin
          pdn_q <= pdn_q & ~SRAM_PDN_MASK;
          st_q  <= U_WSRAM;
        end
        U_WSRAM: begin
          if (sram_awake) begin
            bp_q   <= '0;
            done_q <= 1'b1;
            st_q   <= S_ON;
          end else if (expired) st_q <= S_ERR;
        end
        // ---- power-down ----
        D_SRAM: begin
          pdn_q <= pdn_q | SRAM_PDN_MASK;
          st_q  <= D_WSRAM;
        end
        D_WSRAM: begin
          if (sram_asleep) begin
            iso_q <= 1'b1;
            st_q  <= D_RST;
          end else if (expired) st_q <= S_ERR;
        end
        D_RST:  begin rstn_q   <= 1'b0; st_q <= D_CLK;  end
        D_CLK:  begin clkoff_q <= 1'b1; st_q <= D_PWR1; end
        D_PWR1: begin pon_q    <= 1'b0; st_q <= D_PWR2; end
        D_PWR2: begin pon2_q   <= 1'b0; st_q <= D_WACK; end
        D_WACK: begin
          if (dn_ok) begin
            done_q <= 1'b1;
            st_q   <= S_OFF;
          end else if (expired) st_q <= S_ERR;
        end
        default: st_q <= S_ERR;
      endcase
    end
  end

  assign ctl_word = {pdn_q, {PAD_W{1'b0}}, clkoff_q, pon2_q, pon_q, iso_q, rstn_q};
  assign bus_prot = bp_q;
  assign done     = done_q;
  assign error    = (st_q == S_ERR);
  assign busy     = !((st_q == S_OFF) || (st_q == S_ON) || (st_q == S_ERR));
  assign state    = st_q;

endmodule

// File: rtl/pwr_dom_seq_chk.sv
module pwr_dom_seq_chk
  import pwr_dom_pkg::*;
#(
  parameter int                SRAM_W        = 4,
  parameter logic [SRAM_W-1:0] SRAM_PDN_MASK = '1,
  parameter int                BP_W          = 4,
  parameter logic [BP_W-1:0]   BP_MASK       = 4'h5
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [CB_SRAM_LSB+SRAM_W-1:0] ctl_word,
  input logic [BP_W-1:0]               bus_prot,
  input logic                          done,
  input logic                          busy,
  input logic                          error,
  input logic [3:0]                    state
);

  localparam int TOP = CB_SRAM_LSB + SRAM_W - 1;

  // R4: isolation may only be open while both switches are on
  p_iso_needs_power_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_word[CB_ISO] |-> (ctl_word[CB_PON] && ctl_word[CB_PON2]));

  // R4: reset is released only with the clock running
  p_rst_with_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_word[CB_RSTN] |-> !ctl_word[CB_CLKOFF]);

  // R6: protection is lowered only while the masked SRAM is awake
  p_prot_covers_sram_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_prot != BP_MASK) |-> ((ctl_word[TOP:CB_SRAM_LSB] & SRAM_PDN_MASK) == '0));

  // R5: the settled on state carries the full on word
  p_on_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ON) |-> (ctl_word[CB_RSTN] && !ctl_word[CB_ISO] && ctl_word[CB_PON] &&
                         ctl_word[CB_PON2] && !ctl_word[CB_CLKOFF] && bus_prot == '0));

  // R7: completion in the off state leaves switches open and the island isolated
  p_off_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && state == S_OFF) |-> (!ctl_word[CB_PON] && !ctl_word[CB_PON2] &&
                                  ctl_word[CB_ISO] && !ctl_word[CB_RSTN]));

  // R9: an aborted sequence freezes its outputs
  p_err_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (error && $past(error)) |-> ($stable(ctl_word) && $stable(bus_prot)));

  // R13: busy and error are exclusive
  p_busy_err_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && error));

endmodule

bind pwr_dom_seq pwr_dom_seq_chk #(
  .SRAM_W        (SRAM_W),
  .SRAM_PDN_MASK (SRAM_PDN_MASK),
  .BP_W          (BP_W),
  .BP_MASK       (BP_MASK)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctl_word (ctl_word),
  .bus_prot (bus_prot),
  .done     (done),
  .busy     (busy),
  .error    (error),
  .state    (state)
);

// File: tb/pwr_dom_seq_bench.sv
module pwr_dom_seq_bench;

  localparam int         TO      = 8;
  localparam logic [3:0] PDN_M   = 4'b0111;
  localparam logic [3:0] ACK_M   = 4'b0011;
  localparam logic [3:0] BP_M    = 4'b1001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic on_req = 1'b0, off_req = 1'b0, ack_a = 1'b0, ack_b = 1'b0;
  logic [3:0]  sram_ack = ACK_M;
  logic [11:0] ctl_word;
  logic [3:0]  bus_prot, state;
  logic        done, busy, error;

  // zero-mask instance
  logic on_z = 1'b0, off_z = 1'b0, ack_z = 1'b0;
  logic [3:0]  sack_z = 4'hF;
  logic [11:0] ctl_z;
  logic [3:0]  bp_z, st_z;
  logic        done_z, busy_z, err_z;

  int n_chk = 0;
  int n_bad = 0;
  logic [11:0] ec;
  logic [3:0]  eb;

  always #4 clk = ~clk;

  pwr_dom_seq #(.SRAM_W(4), .SRAM_PDN_MASK(PDN_M), .SACK_W(4), .SRAM_ACK_MASK(ACK_M),
                .BP_W(4), .BP_MASK(BP_M), .TIMEOUT_CYC(TO)) u_pwr_dom_seq (
    .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
    .pwr_ack_a(ack_a), .pwr_ack_b(ack_b), .sram_ack(sram_ack),
    .ctl_word(ctl_word), .bus_prot(bus_prot), .done(done), .busy(busy),
    .error(error), .state(state));

  pwr_dom_seq #(.SRAM_W(4), .SRAM_PDN_MASK(4'hF), .SACK_W(4), .SRAM_ACK_MASK(4'h0),
                .BP_W(4), .BP_MASK(4'h0), .TIMEOUT_CYC(TO)) u_pwr_dom_seq_z (
    .clk(clk), .rst_n(rst_n), .on_req(on_z), .off_req(off_z),
    .pwr_ack_a(ack_z), .pwr_ack_b(ack_z), .sram_ack(sack_z),
    .ctl_word(ctl_z), .bus_prot(bp_z), .done(done_z), .busy(busy_z),
    .error(err_z), .state(st_z));

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cmpw(string req);
    cmp(req, "ctl_word", 32'(ctl_word), 32'(ec));
    cmp(req, "bus_prot", 32'(bus_prot), 32'(eb));
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic run_up(int da, int ds, int mm);
    on_req = 1'b1; step(); on_req = 1'b0;
    ec[2] = 1'b1; cmpw("R2");
    cmp("R13", "busy", 32'(busy), 1);
    cmp("R10", "error", 32'(error), 0);
    step(); ec[3] = 1'b1; cmpw("R2");
    for (int i = 0; i < da; i++) begin
      ack_a = (mm == 0); ack_b = (mm != 0);
      if (i == 0) off_req = 1'b1;
      step(); off_req = 1'b0;
      cmpw("R3");
      cmp("R12", "busy", 32'(busy), 1);
    end
    ack_a = 1'b1; ack_b = 1'b1;
    step(); ec[4] = 1'b0; cmpw("R4");
    step(); ec[1] = 1'b0; cmpw("R4");
    step(); ec[0] = 1'b1; cmpw("R4");
    step(); ec[11:8] = ec[11:8] & ~PDN_M; cmpw("R4");
    for (int i = 0; i < ds; i++) begin
      sram_ack = 4'b0010;
      step(); cmpw("R5");
      cmp("R5", "done", 32'(done), 0);
    end
    sram_ack = 4'b1100;
    step(); eb = 4'h0; cmpw("R5");
    cmp("R5", "done", 32'(done), 1);
    cmp("R5", "state", 32'(state), 1);
    cmp("R13", "busy", 32'(busy), 0);
    step(); cmp("R5", "done pulse", 32'(done), 0);
  endtask

  task automatic run_down(int ds, int dw, int mm);
    off_req = 1'b1; step(); off_req = 1'b0;
    eb = BP_M; cmpw("R6");
    cmp("R13", "busy", 32'(busy), 1);
    cmp("R10", "error", 32'(error), 0);
    step(); ec[11:8] = ec[11:8] | PDN_M; cmpw("R6");
    for (int i = 0; i < ds; i++) begin
      if (i == 0) on_req = 1'b1;
      sram_ack = 4'b0001;
      step(); on_req = 1'b0;
      cmpw("R6");
      cmp("R12", "busy", 32'(busy), 1);
    end
    sram_ack = 4'b0011;
    step(); ec[1] = 1'b1; cmpw("R7");
    step(); ec[0] = 1'b0; cmpw("R7");
    step(); ec[4] = 1'b1; cmpw("R7");
    step(); ec[2] = 1'b0; cmpw("R7");
    step(); ec[3] = 1'b0; cmpw("R7");
    for (int i = 0; i < dw; i++) begin
      ack_a = (mm == 0); ack_b = (mm != 0);
      step(); cmpw("R3");
      cmp("R3", "done", 32'(done), 0);
    end
    ack_a = 1'b0; ack_b = 1'b0;
    step(); cmpw("R7");
    cmp("R7", "done", 32'(done), 1);
    cmp("R7", "state", 32'(state), 0);
    step(); cmp("R7", "done pulse", 32'(done), 0);
  endtask

  initial begin
    repeat (3) step();
    ec = {1'b0, PDN_M, 3'b000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    eb = BP_M;
    cmpw("R1");
    rst_n = 1'b1;
    step();
    cmpw("R1");
    cmp("R1", "state", 32'(state), 0);
    cmp("R1", "done/busy/error", 32'({done, busy, error}), 0);

    // R11: matching request in off state
    off_req = 1'b1; step(); off_req = 1'b0;
    cmp("R11", "done", 32'(done), 1); cmpw("R11");
    cmp("R11", "state", 32'(state), 0);

    // sweep delays and mismatch orders
    for (int mm = 0; mm < 2; mm++)
      for (int da = 0; da < 4; da++)
        for (int ds = 0; ds < 4; ds++) begin
          run_up(da, ds, mm);
          if (da == 1 && ds == 2) begin
            on_req = 1'b1; step(); on_req = 1'b0;
            cmp("R11", "done", 32'(done), 1); cmpw("R11");
            cmp("R11", "state", 32'(state), 1);
          end
          run_down(ds, da, mm);
        end

    // R9: power-ack wait timeout during power-up (split acks)
    ack_a = 1'b1; ack_b = 1'b0;
    on_req = 1'b1; step(); on_req = 1'b0;
    ec[2] = 1'b1; ec[3] = 1'b1;
    repeat (TO) step();
    cmp("R9", "error early", 32'(error), 0);
    cmp("R9", "busy", 32'(busy), 1);
    step();
    cmp("R9", "error", 32'(error), 1);
    cmp("R9", "state", 32'(state), 2);
    cmp("R9", "busy", 32'(busy), 0);
    cmpw("R9");
    repeat (3) step();
    cmpw("R9");
    cmp("R9", "error held", 32'(error), 1);
    run_down(0, 0, 0);   // R10 recovery

    // R9: SRAM wait timeout during power-down
    run_up(0, 0, 0);
    sram_ack = 4'b0000;
    off_req = 1'b1; step(); off_req = 1'b0;
    eb = BP_M; ec[11:8] = ec[11:8] | PDN_M;
    repeat (TO) step();
    cmp("R9", "error early", 32'(error), 0);
    step();
    cmp("R9", "error", 32'(error), 1);
    cmp("R9", "state", 32'(state), 2);
    cmpw("R9");
    run_up(0, 0, 0);     // R10 recovery
    run_down(1, 1, 1);

    // R8: zero-mask instance, sram_ack never cooperates
    ack_z = 1'b1; sack_z = 4'hF;
    on_z = 1'b1; step(); on_z = 1'b0;
    for (int k = 1; k < 7; k++) begin
      cmp("R8", "bus_prot", 32'(bp_z), 0);
      cmp("R8", "done early", 32'(done_z), 0);
      step();
    end
    cmp("R8", "done up", 32'(done_z), 1);
    cmp("R8", "state", 32'(st_z), 1);
    cmp("R8", "ctl on", 32'(ctl_z), 32'h00D);
    sack_z = 4'h0;
    step();
    off_z = 1'b1; step(); off_z = 1'b0;
    for (int k = 1; k < 7; k++) begin
      cmp("R8", "bus_prot", 32'(bp_z), 0);
      step();
    end
    ack_z = 1'b0;
    step();
    cmp("R8", "done down", 32'(done_z), 1);
    cmp("R8", "state", 32'(st_z), 0);
    cmp("R8", "ctl off", 32'(ctl_z), 32'hF12);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule